// File: doc/BRIEF.md
# Vector Signed Shift-Right Accumulate Unit

This block executes one vector instruction of the signed shift-right-and-accumulate kind. It takes the immediate fields of the instruction word and two source vectors: the operand to be shifted and the accumulator. From a single 7-bit immediate it works out both the lane width and the shift distance. In every lane it shifts the operand right with sign fill and adds the result to the matching accumulator lane.

The block has one register stage. A request presented with `in_valid` gives its result, or one of its two error flags, on the next clock edge. The vector is either a full 128-bit vector or a half-width 64-bit vector, and `in_q` selects which. When a request is flagged, the result is held at zero and `out_valid` stays low, so the instruction makes no architectural change.

Top module: `sra_accum_unit`

## Requirements
- R1: The inputs are the instruction's width bit (`in_q`, word bit 30), its 4-bit high immediate (`in_immh`, word bits 22:19) and its 3-bit low immediate (`in_immb`, word bits 18:16). Together they form the 7-bit value {immh, immb}, with immh as the upper bits.
- R2: When `in_immh` is 0000, `out_dec_err` goes to 1, `out_valid` goes to 0 and `out_result` is zero.
- R3: When `in_immh[3]` is 1 and `in_q` is 0, `out_rsv_err` goes to 1, `out_valid` goes to 0 and `out_result` is zero. The two error flags are never high together.
- R4: The lane width is 8 shifted left by the index of the highest set bit of immh. The resulting widths are 8 for 0001, 16 for 001x, 32 for 01xx and 64 for 1xxx.
- R5: The shift distance is twice the lane width minus the unsigned value {immh, immb}. It always falls between 1 and the lane width.
- R6: Each operand lane is shifted right arithmetically, with its sign bit copied into the vacated positions. The shifted value is then added to the accumulator lane at the same position.
- R7: Each lane sum wraps modulo 2 to the power of the lane width, with no saturation, and no carry crosses a lane boundary.
- R8: When `in_q` is 0, bits 127:64 of `out_result` are zero, whatever the upper halves of the input vectors hold.
- R9: A shift distance equal to the lane width turns each operand lane into 0 (non-negative lane) or all ones (negative lane) before the add.
- R10: Outputs are updated one clock after the request. `out_valid` is 1 exactly when `in_valid` was 1 and neither error applied. A cycle with `in_valid` at 0 gives all outputs low.
- R11: While `rst` is high, and on the first cycle after it, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_q | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| in_immh | input | 4 | High immediate field |
| in_immb | input | 3 | Low immediate field |
| in_operand | input | 128 | Vector to be shifted |
| in_accum | input | 128 | Accumulator vector |
| out_valid | output | 1 | Result is valid |
| out_result | output | 128 | Accumulated vector |
| out_dec_err | output | 1 | Undefined encoding (immh zero) |
| out_rsv_err | output | 1 | Reserved encoding (64-bit lanes in half vector) |

## Verification
A wrong lane decode shows on the next clock as every lane boundary in `out_result` being misplaced. A wrong shift distance shows on the next clock as a one-bit scaling error in each lane, which is most visible at the largest and smallest distances. A lost lane mask lets carries leak between lanes, so the bench uses all-ones accumulators that spread the damage to the neighbouring lane within that same cycle. A wrong error decode shows as `out_valid` and a flag that disagree, and as non-zero results on flagged requests.

// File: rtl/sra_pkg.sv
package sra_pkg;

  typedef enum logic [1:0] {
    LANE_8  = 2'd0,
    LANE_16 = 2'd1,
    LANE_32 = 2'd2,
    LANE_64 = 2'd3
  } lane_e;

  typedef struct packed {
    logic       dec_err;
    logic       rsv_err;
    lane_e      lane;
    logic [6:0] shamt;
  } imm_dec_s;

endpackage

// File: rtl/sra_imm_decode.sv
module sra_imm_decode
  import sra_pkg::*;
#(
  parameter int BASE_LANE_W = 8,
  parameter int NUM_SIZES   = 4
) (
  input  logic                 q,
  input  logic [NUM_SIZES-1:0] immh,
  input  logic [2:0]           immb,
  output imm_dec_s             dec
);
  localparam int IMM_W  = NUM_SIZES + 3;
  localparam int WIDE_W = IMM_W + 1;

  logic [1:0]        top_idx;
  logic [WIDE_W-1:0] twice_lane;
  logic [WIDE_W-1:0] shamt_full;

  // R4: highest set bit of immh picks the lane size
  always_comb begin
    top_idx = '0;
    for (int b = 0; b < NUM_SIZES; b++) begin
      if (immh[b]) top_idx = 2'(b);
    end
  end

  // R5: distance = 2*lane - {immh,immb}
  assign twice_lane = WIDE_W'(2 * BASE_LANE_W) << top_idx;
  assign shamt_full = twice_lane - {1'b0, immh, immb};

  always_comb begin
    dec.dec_err = (immh == '0);                                // R2
    dec.rsv_err = !dec.dec_err && immh[NUM_SIZES-1] && !q;     // R3
    dec.lane    = lane_e'(top_idx);
    dec.shamt   = shamt_full[6:0];
  end

  always_comb begin
    if (!dec.dec_err) begin
      AST_SHAMT_IN_RANGE: assert (dec.shamt >= 7'd1 &&
        {1'b0, dec.shamt} <= (8'(BASE_LANE_W) << top_idx)); // R5
    end
  end

endmodule

// File: rtl/sra_lane_alu.sv
module sra_lane_alu #(
  parameter int LANE_W  = 8,
  parameter int SHAMT_W = 7
) (
  input  logic [LANE_W-1:0]  operand,
  input  logic [LANE_W-1:0]  accum,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [LANE_W-1:0]  sum
);
  logic signed [LANE_W-1:0] shifted;

  // R6: sign-filling shift, R7: plain wrapping add inside the lane
  assign shifted = $signed(operand) >>> shamt;
  assign sum     = shifted + accum;

  always_comb begin
    if ({1'b0, shamt} == (SHAMT_W + 1)'(LANE_W)) begin
      AST_FULL_SHIFT_SIGN: assert (shifted == '0 || shifted == '1); // R9
    end
  end

endmodule

// File: rtl/sra_lane_bank.sv
module sra_lane_bank #(
  parameter int DATA_W  = 128,
  parameter int LANE_W  = 8,
  parameter int SHAMT_W = 7
) (
  input  logic [DATA_W-1:0]  operand,
  input  logic [DATA_W-1:0]  accum,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  result
);
  localparam int LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sra_lane_alu #(
      .LANE_W (LANE_W),
      .SHAMT_W(SHAMT_W)
    ) alu_i (
      .operand(operand[l*LANE_W +: LANE_W]),
      .accum  (accum[l*LANE_W +: LANE_W]),
      .shamt  (shamt),
      .sum    (result[l*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/sra_accum_unit.sv
module sra_accum_unit
  import sra_pkg::*;
#(
  parameter int DATA_W      = 128,
  parameter int BASE_LANE_W = 8,
  parameter int NUM_SIZES   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_q,
  input  logic [NUM_SIZES-1:0] in_immh,
  input  logic [2:0]           in_immb,
  input  logic [DATA_W-1:0]    in_operand,
  input  logic [DATA_W-1:0]    in_accum,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    out_result,
  output logic                 out_dec_err,
  output logic                 out_rsv_err
);
  localparam int SHAMT_W = 7;
  localparam int HALF_W  = DATA_W / 2;

  imm_dec_s          dec;
  logic [DATA_W-1:0] res_by_size [NUM_SIZES];
  logic [DATA_W-1:0] picked;
  logic [DATA_W-1:0] masked;
  logic              ok;

  sra_imm_decode #(
    .BASE_LANE_W(BASE_LANE_W),
    .NUM_SIZES  (NUM_SIZES)
  ) dec_i (
    .q   (in_q),
    .immh(in_immh),
    .immb(in_immb),
    .dec (dec)
  );

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    sra_lane_bank #(
      .DATA_W (DATA_W),
      .LANE_W (BASE_LANE_W << s),
      .SHAMT_W(SHAMT_W)
    ) bank_i (
      .operand(in_operand),
      .accum  (in_accum),
      .shamt  (dec.shamt),
      .result (res_by_size[s])
    );
  end

  assign picked = res_by_size[dec.lane];
  // R8: half-width requests clear the upper half
  assign masked = in_q ? picked : {{HALF_W{1'b0}}, picked[HALF_W-1:0]};
  assign ok     = in_valid && !dec.dec_err && !dec.rsv_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_dec_err <= 1'b0;
      out_rsv_err <= 1'b0;
    end else begin
      out_valid   <= ok;
      out_result  <= ok ? masked : '0;
      out_dec_err <= in_valid && dec.dec_err;
      out_rsv_err <= in_valid && dec.rsv_err;
    end
  end

  AST_VALID_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_dec_err && !out_rsv_err); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_dec_err, out_rsv_err})); // R3
  AST_FLAG_ZERO_RESULT: assert property (@(posedge clk) disable iff (rst)
    (out_dec_err || out_rsv_err) |-> out_result == '0); // R2
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_q) |=> out_result[DATA_W-1:HALF_W] == '0); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !out_dec_err && !out_rsv_err); // R10
  AST_ZERO_IMMH_FLAG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_immh == '0) |=> out_dec_err && !out_valid); // R2

endmodule

// File: tb/sra_accum_unit_tb.sv
module sra_accum_unit_tb_top;

  typedef struct {
    logic         v;
    logic         d;
    logic         r;
    logic [127:0] res;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_q = 1'b0;
  logic [3:0]   in_immh = '0;
  logic [2:0]   in_immb = '0;
  logic [127:0] in_operand = '0;
  logic [127:0] in_accum = '0;
  logic         out_valid;
  logic [127:0] out_result;
  logic         out_dec_err;
  logic         out_rsv_err;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;

  sra_accum_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_q(in_q),
    .in_immh(in_immh), .in_immb(in_immb),
    .in_operand(in_operand), .in_accum(in_accum),
    .out_valid(out_valid), .out_result(out_result),
    .out_dec_err(out_dec_err), .out_rsv_err(out_rsv_err)
  );

  function automatic exp_t model(logic q, logic [3:0] h, logic [2:0] b,
                                 logic [127:0] a, logic [127:0] c, string tag);
    exp_t e;
    int   esize;
    int   sh;
    e.tag = tag; e.res = '0; e.v = 0; e.d = 0; e.r = 0;
    if (h == 4'd0) e.d = 1;
    else if (h[3] && !q) e.r = 1;
    else begin
      esize = h[3] ? 64 : h[2] ? 32 : h[1] ? 16 : 8;
      sh = 2 * esize - int'({h, b});
      for (int i = 0; i < 128 / esize; i++) begin
        logic [63:0] m, la, lc, su;
        longint sa, sc;
        m  = (esize == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << esize) - 64'd1);
        la = 64'(a >> (i * esize)) & m;
        lc = 64'(c >> (i * esize)) & m;
        sa = $signed(la << (64 - esize)) >>> (64 - esize);
        sc = (sh >= 64) ? ((sa < 0) ? -64'sd1 : 64'sd0) : (sa >>> sh);
        su = 64'(sc) + lc;
        e.res = e.res | (128'(su & m) << (i * esize));
      end
      if (!q) e.res[127:64] = '0;
      e.v = 1;
    end
    return e;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic send(logic q, logic [3:0] h, logic [2:0] b,
                      logic [127:0] a, logic [127:0] c, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_q = q; in_immh = h; in_immb = b;
    in_operand = a; in_accum = c;
    sb.push_back(model(q, h, b, a, c, tag));
  endtask

  task automatic idle(string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b0; in_immh = $urandom; in_operand = rnd128();
    e.v = 0; e.d = 0; e.r = 0; e.res = '0; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare one scoreboard entry per clock, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (out_valid !== e.v || out_dec_err !== e.d || out_rsv_err !== e.r ||
            out_result !== e.res) begin
          errors++;
          $display("FAIL %s: got v%0b d%0b r%0b %h exp v%0b d%0b r%0b %h", e.tag,
                   out_valid, out_dec_err, out_rsv_err, out_result,
                   e.v, e.d, e.r, e.res);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R11 reset state
    if (out_valid !== 0 || out_result !== '0 || out_dec_err !== 0 || out_rsv_err !== 0) begin
      errors++;
      $display("FAIL R11: got v%0b %h exp 0 0", out_valid, out_result);
    end
    rst = 1'b0;
    idle("R11");

    // R4 R6: byte lanes, distance 1 (immh 0001, immb 111)
    send(1, 4'b0001, 3'b111, 128'h80FF_7F01_0203_F0F1_8081_FEFD_1234_5678,
         128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10, "R6");
    // R9: byte lanes, distance 8
    send(1, 4'b0001, 3'b000, 128'h80FF_7F01_0203_F0F1_8081_FEFD_1234_5678,
         128'h0000_0000_0000_0000_0000_0000_0000_0000, "R9");
    // R9: 64-bit lanes, distance 64 (immh 1000, immb 000)
    send(1, 4'b1000, 3'b000, 128'h8000_0000_0000_0001_7FFF_FFFF_FFFF_FFFF,
         128'h0000_0000_0000_0010_0000_0000_0000_0020, "R9");
    // R4 R5: 16-bit lanes, immh 0011 -> lane 16, distance 32-(24+5)=3
    send(1, 4'b0011, 3'b101, rnd128(), rnd128(), "R5");
    // R5: 32-bit lanes, distance 1
    send(1, 4'b0111, 3'b111, rnd128(), rnd128(), "R5");
    // R4: 64-bit lanes mid distance
    send(1, 4'b1010, 3'b011, rnd128(), rnd128(), "R4");
    // R7: all-ones accumulators to expose cross-lane carry
    send(1, 4'b0001, 3'b111, {16{8'h02}}, {16{8'hFF}}, "R7");
    send(1, 4'b0010, 3'b000, {8{16'h0100}}, {8{16'hFFFF}}, "R7");
    // R8: half vector with busy upper inputs
    send(0, 4'b0100, 3'b010, rnd128(), rnd128(), "R8");
    send(0, 4'b0001, 3'b100, {64'hFFFF_FFFF_FFFF_FFFF, 64'h8070_6050_4030_2010},
         {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, "R8");
    // R2: undefined encoding
    send(1, 4'b0000, 3'b101, rnd128(), rnd128(), "R2");
    // R3: 64-bit lanes in half vector
    send(0, 4'b1001, 3'b001, rnd128(), rnd128(), "R3");
    // R1: field order check, {immh,immb}=0x1F -> lane 16, distance 1
    send(1, 4'b0011, 3'b111, {8{16'h8000}}, {8{16'h0001}}, "R1");
    // R10: idle then back-to-back
    idle("R10");
    send(1, 4'b0001, 3'b001, rnd128(), rnd128(), "R10");
    send(1, 4'b0101, 3'b110, rnd128(), rnd128(), "R10");
    idle("R10");

    for (int k = 0; k < 300; k++) begin
      logic [3:0] h;
      h = 4'($urandom);
      send(1'($urandom), h, 3'($urandom), rnd128(), rnd128(), "R6");
    end
    idle("R10");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule